// File: doc/BRIEF.md
# Stereo Audio Serializer with I2S and LSB-Justified Framing

This block turns parallel stereo sample pairs into the three-wire serial stream that an external audio DAC expects. The three wires are a bit clock, a word select that tells left from right, and one data line that carries both channels. The block runs from a master clock at 256 times the sample rate. It divides that clock by four to make the bit clock, so each stereo frame holds 64 bit periods and each channel slot holds 32.

A static format input picks one of two framings. With the input low, the output is I2S framing: word select is low for the left channel, and the sample starts with its MSB one bit period after each word-select edge. The I2S sample width is set by a static length input in the range 16 to 20 bits, and the slot bits after the sample are zero. With the input high, the output is a 16-bit LSB-justified framing: word select is high for the left channel, and the sample sits at the end of the slot so that its LSB is the last bit before the word-select edge.

Samples enter through a valid/ready handshake. Ready is offered once per frame, in the last master-clock cycle before the left-channel boundary. A pair accepted there is sent in the frame that follows. If no pair is offered, the last pair is sent again.

Top module: `dac_serializer`

## Requirements
- R1: While rst_n is low, bclk, wsel, sdata and in_ready are low. After rst_n is released, in_ready first goes high after the second rising clock edge. The first frame starts at the third rising edge, and until then bclk, wsel and sdata stay low.
- R2: bclk is low for two master-clock cycles and then high for two, starting low at each frame start, which gives 64 bit periods per 256-cycle frame.
- R3: With fmt_sel = 0, wsel is low for the first 32 bit periods of a frame (left) and high for the last 32 (right).
- R4: With fmt_sel = 0, in each 32-bit slot, slot bit 0 is zero and slot bits 1 to N carry sample bits 19 down to 20-N. The 20-bit inputs are MSB-aligned, so bit 19 is the MSB. Every later slot bit is zero. sdata changes only on the master-clock edge where bclk falls.
- R5: The I2S width N equals i2s_len when i2s_len is between 16 and 20. A value below 16 gives 16, and a value above 20 gives 20.
- R6: With fmt_sel = 1, wsel is high for the first 32 bit periods (left) and low for the last 32 (right).
- R7: With fmt_sel = 1, slot bits 0 to 15 are zero and slot bits 16 to 31 carry input bits 19 down to 4. Input bit 4, the LSB, is therefore the last bit before the wsel edge.
- R8: in_ready is high for exactly one master-clock cycle per frame: the last cycle before the left-channel boundary.
- R9: A pair is captured at a rising edge where in_valid and in_ready are both high, and it is sent in the frame that begins at that edge. If in_valid is low at that edge, the previous pair is sent again. After reset, the previous pair is zero.
- R10: in_valid and the sample inputs have no effect on the serial outputs while in_ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fmt_sel | input | 1 | Static format select: 0 = I2S, 1 = 16-bit LSB-justified |
| i2s_len | input | 5 | Static I2S sample width, clamped to 16..20 |
| in_valid | input | 1 | A stereo pair is offered |
| in_ready | output | 1 | Pair accepted at this edge if in_valid is high |
| in_left | input | 20 | Left sample, MSB-aligned |
| in_right | input | 20 | Right sample, MSB-aligned |
| bclk | output | 1 | Serial bit clock, master clock divided by 4 |
| wsel | output | 1 | Left/right word select |
| sdata | output | 1 | Serial data, both channels |

## Verification
Each output is a register loaded from the next value of the frame counter. So bclk, wsel and sdata show the bit position of a master-clock cycle in the same cycle in which that position's counter value sits in the register, and in_ready is decoded from the counter in that same cycle. A captured pair first shows up four master cycles after the accepting edge, as the MSB of an I2S slot, or 64 cycles after it, as the left-slot data of the LSB-justified framing. The reference model advances one frame position at each rising edge and holds its own copy of the accepted pair. All four outputs are compared with it at every falling edge. This covers reset, the two-edge release, repeated pairs, data offered while not ready, and every width clamp.

// File: rtl/dsr_pkg.sv
`timescale 1ns/1ps
package dsr_pkg;

  // Framing choice, taken from a static pin.
  typedef enum logic {
    FMT_I2S  = 1'b0,
    FMT_LSBJ = 1'b1
  } fmt_e;

  // One serial bit position: word select and data.
  typedef struct packed {
    logic ws;
    logic sd;
  } line_t;

endpackage

// File: rtl/dsr_rst_sync.sv
`timescale 1ns/1ps
module dsr_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/dsr_frame_timer.sv
`timescale 1ns/1ps
module dsr_frame_timer #(
  parameter int CNT_W = 8,
  parameter int PH_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             frame_last,
  output logic             bit_start,
  output logic             bclk_nxt
);

  logic [CNT_W-1:0] cnt_q;

  // Next state: free-running position within the frame.
  always_comb begin
    cnt_nxt = cnt_q + CNT_W'(1);
  end

  // Reset to the last position, so the first increment opens a frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end

  assign frame_last = &cnt_q;
  assign bit_start  = (cnt_nxt[PH_W-1:0] == '0);
  assign bclk_nxt   = cnt_nxt[PH_W-1];

endmodule

// File: rtl/dsr_sample_hold.sv
`timescale 1ns/1ps
module dsr_sample_hold #(
  parameter int SAMPLE_W = 20,
  parameter int CHANNELS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [CHANNELS*SAMPLE_W-1:0] din,
  output logic [CHANNELS*SAMPLE_W-1:0] dout
);

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
    logic [SAMPLE_W-1:0] hold_q;
    logic [SAMPLE_W-1:0] hold_d;

    always_comb begin
      hold_d = hold_q;
      if (load) begin
        hold_d = din[ch*SAMPLE_W +: SAMPLE_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= '0;
      end else begin
        hold_q <= hold_d;
      end
    end

    assign dout[ch*SAMPLE_W +: SAMPLE_W] = hold_q;
  end

endmodule

// File: rtl/dsr_bit_picker.sv
`timescale 1ns/1ps
module dsr_bit_picker #(
  parameter int SAMPLE_W = 20,
  parameter int SLOT_W   = 32,
  parameter int LSBJ_W   = 16,
  parameter int BIT_W    = 6,
  parameter int LEN_W    = 5
) (
  input  dsr_pkg::fmt_e       fmt,
  input  logic [LEN_W-1:0]    len_eff,
  input  logic [BIT_W-1:0]    bit_idx,
  input  logic [SAMPLE_W-1:0] smp_l,
  input  logic [SAMPLE_W-1:0] smp_r,
  output dsr_pkg::line_t      line
);

  localparam int POS_W    = BIT_W - 1;
  localparam int LSBJ_OFS = SLOT_W - LSBJ_W;

  logic                right_half;
  logic [POS_W-1:0]    pos;
  logic [SAMPLE_W-1:0] smp;
  logic                i2s_bit;
  logic                lsbj_bit;

  always_comb begin
    right_half = bit_idx[BIT_W-1];
    pos        = bit_idx[POS_W-1:0];
    smp        = right_half ? smp_r : smp_l;
  end

  // MSB-first after a one-bit lead, cut off at the configured width.
  always_comb begin
    i2s_bit = 1'b0;
    for (int j = 0; j < SAMPLE_W; j++) begin
      if ((int'(pos) == j + 1) && (j < int'(len_eff))) begin
        i2s_bit = smp[SAMPLE_W-1-j];
      end
    end
  end

  // Top LSBJ_W bits packed against the end of the slot.
  always_comb begin
    lsbj_bit = 1'b0;
    for (int j = 0; j < LSBJ_W; j++) begin
      if (int'(pos) == LSBJ_OFS + j) begin
        lsbj_bit = smp[SAMPLE_W-1-j];
      end
    end
  end

  always_comb begin
    if (fmt == dsr_pkg::FMT_I2S) begin
      line.ws = right_half;
      line.sd = i2s_bit;
    end else begin
      line.ws = ~right_half;
      line.sd = lsbj_bit;
    end
  end

endmodule

// File: rtl/dac_serializer.sv
`timescale 1ns/1ps
module dac_serializer #(
  parameter int SAMPLE_W = 20,
  parameter int I2S_MIN  = 16,
  parameter int I2S_MAX  = 20,
  parameter int LSBJ_W   = 16,
  parameter int SLOT_W   = 32,
  parameter int MCLK_DIV = 4,
  localparam int LEN_W   = $clog2(I2S_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fmt_sel,
  input  logic [LEN_W-1:0]    i2s_len,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                bclk,
  output logic                wsel,
  output logic                sdata
);

  localparam int BIT_W = $clog2(2 * SLOT_W);
  localparam int PH_W  = $clog2(MCLK_DIV);
  localparam int CNT_W = BIT_W + PH_W;

  logic                  rst_int_n;
  logic [CNT_W-1:0]      cnt_nxt;
  logic                  frame_last;
  logic                  bit_start;
  logic                  bclk_nxt;
  logic                  load;
  logic [2*SAMPLE_W-1:0] held;
  logic [LEN_W-1:0]      len_eff;
  dsr_pkg::line_t        pick;

  logic bclk_q, bclk_d;
  logic wsel_q, wsel_d;
  logic sdata_q, sdata_d;

  dsr_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_int_n)
  );

  dsr_frame_timer #(
    .CNT_W (CNT_W),
    .PH_W  (PH_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cnt_nxt    (cnt_nxt),
    .frame_last (frame_last),
    .bit_start  (bit_start),
    .bclk_nxt   (bclk_nxt)
  );

  // Handshake: one acceptance slot per frame, at the left boundary.
  assign in_ready = frame_last & rst_int_n;
  assign load     = in_valid & in_ready;

  dsr_sample_hold #(
    .SAMPLE_W (SAMPLE_W),
    .CHANNELS (2)
  ) u_hold (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (load),
    .din   ({in_right, in_left}),
    .dout  (held)
  );

  // Width clamp for the I2S framing.
  always_comb begin
    if (i2s_len < LEN_W'(I2S_MIN)) begin
      len_eff = LEN_W'(I2S_MIN);
    end else if (i2s_len > LEN_W'(I2S_MAX)) begin
      len_eff = LEN_W'(I2S_MAX);
    end else begin
      len_eff = i2s_len;
    end
  end

  dsr_bit_picker #(
    .SAMPLE_W (SAMPLE_W),
    .SLOT_W   (SLOT_W),
    .LSBJ_W   (LSBJ_W),
    .BIT_W    (BIT_W),
    .LEN_W    (LEN_W)
  ) u_pick (
    .fmt     (dsr_pkg::fmt_e'(fmt_sel)),
    .len_eff (len_eff),
    .bit_idx (cnt_nxt[CNT_W-1:PH_W]),
    .smp_l   (held[SAMPLE_W-1:0]),
    .smp_r   (held[2*SAMPLE_W-1:SAMPLE_W]),
    .line    (pick)
  );

  // Output stage: the line updates only where the bit clock falls.
  always_comb begin
    bclk_d  = bclk_nxt;
    wsel_d  = wsel_q;
    sdata_d = sdata_q;
    if (bit_start) begin
      wsel_d  = pick.ws;
      sdata_d = pick.sd;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bclk_q  <= 1'b0;
      wsel_q  <= 1'b0;
      sdata_q <= 1'b0;
    end else begin
      bclk_q  <= bclk_d;
      wsel_q  <= wsel_d;
      sdata_q <= sdata_d;
    end
  end

  assign bclk  = bclk_q;
  assign wsel  = wsel_q;
  assign sdata = sdata_q;

endmodule

// File: rtl/dac_serializer_chk.sv
`timescale 1ns/1ps
module dac_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic bclk,
  input logic wsel,
  input logic sdata
);

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready); // R8

  AST_BCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk) |=> bclk); // R2

  AST_BCLK_LOW_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bclk) |=> !bclk); // R2

  AST_SDATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $fell(bclk)); // R4

  AST_WSEL_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wsel) |-> !bclk); // R3

  AST_LEAD_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wsel) |-> !sdata); // R7

endmodule

bind dac_serializer dac_serializer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .bclk     (bclk),
  .wsel     (wsel),
  .sdata    (sdata)
);

// File: tb/dac_serializer_tb.sv
`timescale 1ns/1ps
module dac_serializer_tb;

  logic        clk;
  logic        rst_n;
  logic        fmt_sel;
  logic [4:0]  i2s_len;
  logic        in_valid;
  logic [19:0] in_left;
  logic [19:0] in_right;
  logic        in_ready;
  logic        bclk;
  logic        wsel;
  logic        sdata;

  int    errors;
  int    checks;
  bit    done;
  int    drv_mode;
  string scen;

  // Reference model state
  int          rel;
  int          pos;
  bit          started;
  logic [19:0] ml;
  logic [19:0] mr;

  dac_serializer u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt_sel  (fmt_sel),
    .i2s_len  (i2s_len),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_left  (in_left),
    .in_right (in_right),
    .bclk     (bclk),
    .wsel     (wsel),
    .sdata    (sdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int eff_len(int v);
    if (v < 16) return 16;
    if (v > 20) return 20;
    return v;
  endfunction

  function automatic bit exp_sd(int p_in, bit f, int w, logic [19:0] l, logic [19:0] r);
    int          k;
    int          p;
    logic [19:0] s;
    k = p_in / 4;
    p = k % 32;
    s = (k >= 32) ? r : l;
    if (!f) return (p >= 1 && p <= w) ? s[20-p] : 1'b0;
    return (p >= 16) ? s[19-(p-16)] : 1'b0;
  endfunction

  // Behavioural frame model, one position per rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0; pos = 255; started = 0; ml = '0; mr = '0;
    end else begin
      if (rel >= 2 && pos == 255 && in_valid) begin
        ml = in_left;
        mr = in_right;
      end
      if (rel >= 2) begin
        pos = (pos + 1) % 256;
        if (pos == 0) started = 1;
      end
      if (rel < 2) rel++;
    end
  end

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
    end
  endtask

  // Compare on the falling edge, then drive the next inputs.
  always @(negedge clk) begin
    if (!done) begin
      bit e_rdy;
      bit half;
      e_rdy = (rel >= 2 && pos == 255);
      if (!started) begin
        chk("R1 in_ready", in_ready, e_rdy);
        chk("R1 bclk", bclk, 1'b0);
        chk("R1 wsel", wsel, 1'b0);
        chk("R1 sdata", sdata, 1'b0);
      end else begin
        half = (pos / 4) >= 32;
        chk("R8 in_ready", in_ready, e_rdy);
        chk("R2 bclk", bclk, (pos % 4) >= 2);
        chk(fmt_sel ? "R6 wsel" : "R3 wsel", wsel, fmt_sel ? !half : half);
        chk({fmt_sel ? "R7" : "R4", "/", scen, " sdata"}, sdata,
            exp_sd(pos, fmt_sel, eff_len(int'(i2s_len)), ml, mr));
      end
      in_left  = 20'($urandom);
      in_right = 20'($urandom);
      case (drv_mode)
        0:       in_valid = 1'b1;
        1:       in_valid = 1'($urandom);
        default: in_valid = 1'b0;
      endcase
    end
  end

  task automatic do_reset(bit f, int len);
    @(negedge clk);
    #2;
    rst_n   = 1'b0;
    fmt_sel = f;
    i2s_len = 5'(len);
    repeat (3) @(negedge clk);
    #2;
    rst_n = 1'b1;
  endtask

  task automatic run_frames(int mode, string tag, int n);
    drv_mode = mode;
    scen     = tag;
    repeat (n * 256) @(negedge clk);
  endtask

  initial begin
    errors = 0; checks = 0; done = 0;
    rel = 0; pos = 255; started = 0; ml = '0; mr = '0;
    drv_mode = 0; scen = "R10";
    rst_n = 1'b0; fmt_sel = 1'b0; i2s_len = 5'd20;
    in_valid = 1'b0; in_left = '0; in_right = '0;

    // I2S, full width: continuous offers, sparse offers, none
    do_reset(1'b0, 20);
    run_frames(0, "R10", 3);
    run_frames(1, "R9", 3);
    run_frames(2, "R9", 2);
    // I2S width settings and clamps
    do_reset(1'b0, 16);
    run_frames(1, "R5", 2);
    do_reset(1'b0, 18);
    run_frames(0, "R5", 2);
    do_reset(1'b0, 3);
    run_frames(1, "R5", 2);
    do_reset(1'b0, 31);
    run_frames(1, "R5", 2);
    // LSB-justified
    do_reset(1'b1, 20);
    run_frames(0, "R10", 2);
    run_frames(1, "R9", 2);
    run_frames(2, "R9", 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule